// File: doc/BRIEF.md
# DMA Channel Abort and Error Status Unit

This unit decides how an active DMA channel comes to an end. It follows the data engine beat by beat: each read-write sequence is a read phase followed by a write phase. For each sequence the engine says whether it is the final one of the current minor or major loop. The unit reacts to bus error responses on reads and writes and to the two cancel requests, a plain cancel and an error cancel. It then emits either a terminate pulse (abnormal end) or a retire pulse (normal end at the final sequence).

The stop is not always immediate. A failed read that was the last of its read phase still lets the write phase run, using the data the engine captured. A failed write that was the last of its write phase still lets the next read phase run. A cancel waits for the current sequence to finish. A cancel that arrives while the final sequence of a loop is in progress is dropped, and the channel retires normally.

Whenever the descriptor must be updated, the unit pulses a write-back strobe. It carries the source address, destination address and remaining byte count presented by the engine. The unit also holds a status register with the last error and drives an error interrupt.

Top module: `dma_abort_unit`

## Requirements
- R1: After reset the outputs term_o, retire_o, wb_valid_o, cx_pend_o, ecx_pend_o, st_valid_o, st_src_err_o, st_dst_err_o, st_ecx_o and err_irq_o are 0.
- R2: A read beat with an error that is not the last read of its phase gives term_o high in the cycle after that beat. No further beat is needed, and the status shows st_src_err_o=1, st_dst_err_o=0.
- R3: Every bus error beat gives wb_valid_o in the following cycle. wb_src_o, wb_dst_o and wb_nbytes_o then equal cur_src_i, cur_dst_i and cur_nbytes_i as presented with the faulting beat.
- R4: A read error on the last read beat of a phase lets the whole write phase of that sequence run. term_o follows the last write beat.
- R5: A write error on the last write beat of a non-final sequence lets the next read phase run. term_o follows its last read beat. In the final sequence, term_o follows the faulting beat itself.
- R6: A write error on a write beat that is not the last of its phase gives term_o in the next cycle, with st_dst_err_o=1 and st_src_err_o=0.
- R7: An accepted plain cancel ends the channel with term_o after the last write beat of the current sequence. It gives one wb_valid_o carrying the values presented with that beat, and it leaves st_valid_o at 0.
- R8: A cancel or error cancel handled while seq_final_i is 1 is discarded. The channel then retires with retire_o and logs nothing.
- R9: An accepted error cancel ends the channel as in R7 and also sets st_valid_o=1, st_ecx_o=1, st_src_err_o=0, st_dst_err_o=0 and st_chan_o to the channel number.
- R10: err_irq_o rises when an error or accepted error cancel is logged for a channel activated with act_irq_en_i=1. It stays 0 if the channel was activated with act_irq_en_i=0, and it is cleared by st_clr_i.
- R11: A request pulse on cx_req_i or ecx_req_i sets the matching pending output in the next cycle. The unit clears it again in the cycle after that, once it has acted on the request or dropped it.
- R12: Each newly logged error overwrites the channel and cause fields, so only the newest cause bit is set. st_clr_i in a cycle with no new log clears st_valid_o.
- R13: A write beat with no error that is the last of the final sequence, with no pending stop, gives retire_o in the next cycle and no term_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_i | input | 1 | Channel activation pulse |
| act_chan_i | input | CHAN_W | Number of the activated channel |
| act_irq_en_i | input | 1 | Error interrupt enable of the activated channel |
| beat_valid_i | input | 1 | A bus beat completes this cycle |
| beat_wr_i | input | 1 | Beat is a write (1) or a read (0) |
| beat_last_i | input | 1 | Beat is the last of its read or write phase |
| beat_err_i | input | 1 | Beat ended with a bus error response |
| seq_final_i | input | 1 | Current sequence is the last of its loop |
| cur_src_i | input | ADDR_W | Current source address from the engine |
| cur_dst_i | input | ADDR_W | Current destination address from the engine |
| cur_nbytes_i | input | NBYTES_W | Current remaining byte count from the engine |
| cx_req_i | input | 1 | Plain cancel request pulse |
| ecx_req_i | input | 1 | Error cancel request pulse |
| st_clr_i | input | 1 | Status and interrupt clear strobe |
| cx_pend_o | output | 1 | Plain cancel request pending |
| ecx_pend_o | output | 1 | Error cancel request pending |
| term_o | output | 1 | Channel terminated (abnormal end) pulse |
| retire_o | output | 1 | Channel retired normally pulse |
| wb_valid_o | output | 1 | Descriptor write-back strobe |
| wb_src_o | output | ADDR_W | Source address to write back |
| wb_dst_o | output | ADDR_W | Destination address to write back |
| wb_nbytes_o | output | NBYTES_W | Byte count to write back |
| st_valid_o | output | 1 | Status holds a logged error |
| st_chan_o | output | CHAN_W | Channel of the logged error |
| st_src_err_o | output | 1 | Logged cause: read bus error |
| st_dst_err_o | output | 1 | Logged cause: write bus error |
| st_ecx_o | output | 1 | Logged cause: error cancel |
| err_irq_o | output | 1 | Error interrupt |

## Verification
Channels are run with random sequence counts and phase lengths. In each run exactly one event is placed at a random sequence and beat: a read error, a write error, a plain cancel or an error cancel; some runs have no event at all. Whether the faulting beat was the last of its phase, and whether the sequence was the final one, separates an immediate abort from a deferred end. The number of beats performed before term_o or retire_o shows which of the two the design chose. The write-back values show whether the fault beat or the end beat was captured. Directed cases cover a read error on the last read followed by a write error during the deferred writes, interrupt gating, and pending bits that clear themselves.

// File: rtl/dma_abort_pkg.sv
package dma_abort_pkg;

    // Cause recorded into the status register in a given cycle
    typedef enum logic [1:0] {
        LOG_NONE = 2'd0,
        LOG_SRC  = 2'd1,
        LOG_DST  = 2'd2,
        LOG_ECX  = 2'd3
    } log_kind_e;

    // Deferred end of the active channel
    typedef enum logic [1:0] {
        STOP_NONE     = 2'd0,
        STOP_AFTER_WR = 2'd1,  // read failed on last read: end after write phase
        STOP_AFTER_RD = 2'd2,  // write failed on last write: end after next read phase
        STOP_CANCEL   = 2'd3   // cancel accepted: end after write phase with write-back
    } stop_e;

endpackage

// File: rtl/dma_cancel_req.sv
module dma_cancel_req (
    input  logic clk,
    input  logic rst_n,
    input  logic cx_req_i,
    input  logic ecx_req_i,
    input  logic ack_i,
    output logic cx_pend_o,
    output logic ecx_pend_o
);
    typedef struct packed {
        logic cx;
        logic ecx;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d     = req_q;
        if (ack_i) begin
            req_d.cx  = 1'b0;
            req_d.ecx = 1'b0;
        end
        if (cx_req_i)  req_d.cx  = 1'b1;
        if (ecx_req_i) req_d.ecx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign cx_pend_o  = req_q.cx;
    assign ecx_pend_o = req_q.ecx;

    // R11
    cx_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cx_req_i |=> cx_pend_o);

    // R11
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cx_req_i && !ecx_req_i) |=> (!cx_pend_o && !ecx_pend_o));

endmodule

// File: rtl/dma_abort_ctrl.sv
module dma_abort_ctrl
    import dma_abort_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [CHAN_W-1:0] act_chan_i,
    input  logic              act_irq_en_i,
    input  logic              beat_valid_i,
    input  logic              beat_wr_i,
    input  logic              beat_last_i,
    input  logic              beat_err_i,
    input  logic              seq_final_i,
    input  logic              cx_pend_i,
    input  logic              ecx_pend_i,
    output logic              req_ack_o,
    output logic              wb_take_o,
    output log_kind_e         log_kind_o,
    output logic [CHAN_W-1:0] log_chan_o,
    output logic              log_irq_en_o,
    output logic              term_o,
    output logic              retire_o
);
    typedef struct packed {
        logic              active;
        logic [CHAN_W-1:0] chan;
        logic              irq_en;
        stop_e             stop;
        logic              term;
        logic              retire;
    } ctrl_t;

    ctrl_t     ctl_d, ctl_q;
    logic      ending;
    logic      err_now;
    logic      take;
    logic      ack;
    log_kind_e kind;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.term   = 1'b0;
        ctl_d.retire = 1'b0;
        ending       = 1'b0;
        take         = 1'b0;
        ack          = 1'b0;
        kind         = LOG_NONE;
        err_now      = beat_valid_i && beat_err_i;

        if (!ctl_q.active) begin
            // Requests with no channel in service are dropped
            ack = cx_pend_i | ecx_pend_i;
            if (act_i) begin
                ctl_d.active = 1'b1;
                ctl_d.chan   = act_chan_i;
                ctl_d.irq_en = act_irq_en_i;
                ctl_d.stop   = STOP_NONE;
            end
        end else begin
            if (beat_valid_i && !beat_wr_i) begin
                if (beat_err_i) begin
                    kind = LOG_SRC;
                    take = 1'b1;
                    if (!beat_last_i || ctl_q.stop == STOP_AFTER_RD) ending = 1'b1;
                    else                                             ctl_d.stop = STOP_AFTER_WR;
                end else if (beat_last_i && ctl_q.stop == STOP_AFTER_RD) begin
                    ending = 1'b1;
                end
            end else if (beat_valid_i && beat_wr_i) begin
                if (beat_err_i) begin
                    kind = LOG_DST;
                    take = 1'b1;
                    if (!beat_last_i || seq_final_i || ctl_q.stop != STOP_NONE) ending = 1'b1;
                    else                                                       ctl_d.stop = STOP_AFTER_RD;
                end else if (beat_last_i) begin
                    if (ctl_q.stop == STOP_AFTER_WR) begin
                        ending = 1'b1;
                    end else if (ctl_q.stop == STOP_CANCEL) begin
                        ending = 1'b1;
                        take   = 1'b1;
                    end else if (seq_final_i) begin
                        ctl_d.retire = 1'b1;
                        ctl_d.active = 1'b0;
                    end
                end
            end

            // Cancel handling waits for a cycle without a bus error
            if ((cx_pend_i || ecx_pend_i) && !err_now && !ending && !ctl_d.retire) begin
                ack = 1'b1;
                if (ctl_q.stop == STOP_NONE && !seq_final_i) begin
                    if (ecx_pend_i) kind = LOG_ECX;
                    if (beat_valid_i && beat_wr_i && beat_last_i) begin
                        ending = 1'b1;
                        take   = 1'b1;
                    end else begin
                        ctl_d.stop = STOP_CANCEL;
                    end
                end
            end

            if (ending) begin
                ctl_d.term   = 1'b1;
                ctl_d.active = 1'b0;
                ctl_d.stop   = STOP_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ack_o    = ack;
    assign wb_take_o    = take;
    assign log_kind_o   = kind;
    assign log_chan_o   = ctl_q.chan;
    assign log_irq_en_o = ctl_q.irq_en;
    assign term_o       = ctl_q.term;
    assign retire_o     = ctl_q.retire;

    // R2
    rd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && beat_valid_i && !beat_wr_i && beat_err_i && !beat_last_i) |=> term_o);

    // R6
    wr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && beat_valid_i && beat_wr_i && beat_err_i && !beat_last_i) |=> term_o);

    // R7
    cancel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ctl_q.stop == STOP_CANCEL && beat_valid_i && beat_wr_i
         && beat_last_i && !beat_err_i) |=> (term_o && !retire_o));

    // R8
    final_cancel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ctl_q.stop == STOP_NONE && seq_final_i && !beat_valid_i
         && (cx_pend_i || ecx_pend_i)) |=> (ctl_q.stop == STOP_NONE && !term_o));

    // R13
    retire_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |-> $past(beat_valid_i && beat_wr_i && beat_last_i && seq_final_i && !beat_err_i));

endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
    import dma_abort_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  log_kind_e         log_kind_i,
    input  logic [CHAN_W-1:0] log_chan_i,
    input  logic              log_irq_en_i,
    input  logic              clr_i,
    output logic              st_valid_o,
    output logic [CHAN_W-1:0] st_chan_o,
    output logic              st_src_err_o,
    output logic              st_dst_err_o,
    output logic              st_ecx_o,
    output logic              err_irq_o
);
    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic              src;
        logic              dst;
        logic              ecx;
        logic              irq;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (log_kind_i != LOG_NONE) begin
            st_d.valid = 1'b1;
            st_d.chan  = log_chan_i;
            st_d.src   = (log_kind_i == LOG_SRC);
            st_d.dst   = (log_kind_i == LOG_DST);
            st_d.ecx   = (log_kind_i == LOG_ECX);
            st_d.irq   = st_q.irq | log_irq_en_i;
        end else if (clr_i) begin
            st_d.valid = 1'b0;
            st_d.irq   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_valid_o   = st_q.valid;
    assign st_chan_o    = st_q.chan;
    assign st_src_err_o = st_q.src;
    assign st_dst_err_o = st_q.dst;
    assign st_ecx_o     = st_q.ecx;
    assign err_irq_o    = st_q.irq;

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && log_kind_i == LOG_NONE) |=> (!st_valid_o && !err_irq_o));

    // R9
    ecx_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_kind_i == LOG_ECX) |=> (st_valid_o && st_ecx_o && !st_src_err_o
                                     && !st_dst_err_o && st_chan_o == $past(log_chan_i)));

    // R12
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o |-> $onehot({st_src_err_o, st_dst_err_o, st_ecx_o}));

endmodule

// File: rtl/dma_wb_capture.sv
module dma_wb_capture #(
    parameter int ADDR_W   = 32,
    parameter int NBYTES_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic [ADDR_W-1:0]   cur_src_i,
    input  logic [ADDR_W-1:0]   cur_dst_i,
    input  logic [NBYTES_W-1:0] cur_nbytes_i,
    output logic                wb_valid_o,
    output logic [ADDR_W-1:0]   wb_src_o,
    output logic [ADDR_W-1:0]   wb_dst_o,
    output logic [NBYTES_W-1:0] wb_nbytes_o
);
    typedef struct packed {
        logic                valid;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [NBYTES_W-1:0] nbytes;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = take_i;
        if (take_i) begin
            wb_d.src    = cur_src_i;
            wb_d.dst    = cur_dst_i;
            wb_d.nbytes = cur_nbytes_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_valid_o  = wb_q.valid;
    assign wb_src_o    = wb_q.src;
    assign wb_dst_o    = wb_q.dst;
    assign wb_nbytes_o = wb_q.nbytes;

    // R3
    wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (wb_valid_o && wb_src_o == $past(cur_src_i)
                    && wb_dst_o == $past(cur_dst_i) && wb_nbytes_o == $past(cur_nbytes_i)));

    // R3
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> (!wb_valid_o && $stable(wb_src_o)));

endmodule

// File: rtl/dma_abort_unit.sv
module dma_abort_unit
    import dma_abort_pkg::*;
#(
    parameter int NUM_CHAN = 32,
    parameter int ADDR_W   = 32,
    parameter int NBYTES_W = 16,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                act_i,
    input  logic [CHAN_W-1:0]   act_chan_i,
    input  logic                act_irq_en_i,
    input  logic                beat_valid_i,
    input  logic                beat_wr_i,
    input  logic                beat_last_i,
    input  logic                beat_err_i,
    input  logic                seq_final_i,
    input  logic [ADDR_W-1:0]   cur_src_i,
    input  logic [ADDR_W-1:0]   cur_dst_i,
    input  logic [NBYTES_W-1:0] cur_nbytes_i,
    input  logic                cx_req_i,
    input  logic                ecx_req_i,
    input  logic                st_clr_i,
    output logic                cx_pend_o,
    output logic                ecx_pend_o,
    output logic                term_o,
    output logic                retire_o,
    output logic                wb_valid_o,
    output logic [ADDR_W-1:0]   wb_src_o,
    output logic [ADDR_W-1:0]   wb_dst_o,
    output logic [NBYTES_W-1:0] wb_nbytes_o,
    output logic                st_valid_o,
    output logic [CHAN_W-1:0]   st_chan_o,
    output logic                st_src_err_o,
    output logic                st_dst_err_o,
    output logic                st_ecx_o,
    output logic                err_irq_o
);
    logic              req_ack;
    logic              wb_take;
    log_kind_e         log_kind;
    logic [CHAN_W-1:0] log_chan;
    logic              log_irq_en;

    dma_cancel_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .cx_req_i   (cx_req_i),
        .ecx_req_i  (ecx_req_i),
        .ack_i      (req_ack),
        .cx_pend_o  (cx_pend_o),
        .ecx_pend_o (ecx_pend_o)
    );

    dma_abort_ctrl #(.CHAN_W(CHAN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (act_i),
        .act_chan_i   (act_chan_i),
        .act_irq_en_i (act_irq_en_i),
        .beat_valid_i (beat_valid_i),
        .beat_wr_i    (beat_wr_i),
        .beat_last_i  (beat_last_i),
        .beat_err_i   (beat_err_i),
        .seq_final_i  (seq_final_i),
        .cx_pend_i    (cx_pend_o),
        .ecx_pend_i   (ecx_pend_o),
        .req_ack_o    (req_ack),
        .wb_take_o    (wb_take),
        .log_kind_o   (log_kind),
        .log_chan_o   (log_chan),
        .log_irq_en_o (log_irq_en),
        .term_o       (term_o),
        .retire_o     (retire_o)
    );

    dma_err_status #(.CHAN_W(CHAN_W)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .log_kind_i   (log_kind),
        .log_chan_i   (log_chan),
        .log_irq_en_i (log_irq_en),
        .clr_i        (st_clr_i),
        .st_valid_o   (st_valid_o),
        .st_chan_o    (st_chan_o),
        .st_src_err_o (st_src_err_o),
        .st_dst_err_o (st_dst_err_o),
        .st_ecx_o     (st_ecx_o),
        .err_irq_o    (err_irq_o)
    );

    dma_wb_capture #(.ADDR_W(ADDR_W), .NBYTES_W(NBYTES_W)) u_wb (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (wb_take),
        .cur_src_i    (cur_src_i),
        .cur_dst_i    (cur_dst_i),
        .cur_nbytes_i (cur_nbytes_i),
        .wb_valid_o   (wb_valid_o),
        .wb_src_o     (wb_src_o),
        .wb_dst_o     (wb_dst_o),
        .wb_nbytes_o  (wb_nbytes_o)
    );

    // R13
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(term_o && retire_o));

endmodule

// File: tb/dma_abort_unit_test.sv
module dma_abort_unit_test;
    localparam int CW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_i = 0, act_irq_en_i = 0;
    logic [CW-1:0] act_chan_i = '0;
    logic        beat_valid_i = 0, beat_wr_i = 0, beat_last_i = 0, beat_err_i = 0;
    logic        seq_final_i = 0;
    logic [31:0] cur_src_i = '0, cur_dst_i = '0;
    logic [15:0] cur_nbytes_i = '0;
    logic        cx_req_i = 0, ecx_req_i = 0, st_clr_i = 0;
    logic        cx_pend_o, ecx_pend_o, term_o, retire_o, wb_valid_o;
    logic [31:0] wb_src_o, wb_dst_o;
    logic [15:0] wb_nbytes_o;
    logic        st_valid_o, st_src_err_o, st_dst_err_o, st_ecx_o, err_irq_o;
    logic [CW-1:0] st_chan_o;

    dma_abort_unit uut (.*);

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0, errors = 0;
    bit finished = 0;
    // per-run observations
    int cnt, wbn, end_cnt;
    bit ended, got_term, got_ret;
    logic [31:0] ws, wd;
    logic [15:0] wn;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] src_of(int i); return 32'h1000 + 32'(4 * i); endfunction
    function automatic logic [31:0] dst_of(int i); return 32'h8000 + 32'(8 * i); endfunction
    function automatic logic [15:0] nb_of(int i);  return 16'(1000 - i); endfunction

    // kinds: 0 none, 1 read error, 2 write error, 3 cancel, 4 error cancel
    function automatic int exp_beats(int kind, int s, int k, int n, int b, output bit ret);
        ret = 0;
        case (kind)
            1: return (k < b - 1) ? s * 2 * b + k + 1 : (s + 1) * 2 * b;
            2: begin
                if (k < b - 1)  return s * 2 * b + b + k + 1;
                if (s == n - 1) return n * 2 * b;
                return (s + 1) * 2 * b + b;
            end
            3, 4: begin
                if (s == n - 1) begin ret = 1; return n * 2 * b; end
                return (s + 1) * 2 * b;
            end
            default: begin ret = 1; return n * 2 * b; end
        endcase
    endfunction

    function automatic string tag_of(int kind, int s, int k, int n, int b);
        case (kind)
            1: return (k < b - 1) ? "R2" : "R4";
            2: return (k < b - 1) ? "R6" : "R5";
            3: return (s == n - 1) ? "R8" : "R7";
            4: return (s == n - 1) ? "R8" : "R9";
            default: return "R13";
        endcase
    endfunction

    task automatic drive_beat(bit wr, bit last, bit err);
        beat_valid_i = 1; beat_wr_i = wr; beat_last_i = last; beat_err_i = err;
        cur_src_i = src_of(cnt); cur_dst_i = dst_of(cnt); cur_nbytes_i = nb_of(cnt);
        @(negedge clk);
        beat_valid_i = 0; beat_err_i = 0; beat_last_i = 0;
        cnt++;
        if (wb_valid_o) begin wbn++; ws = wb_src_o; wd = wb_dst_o; wn = wb_nbytes_o; end
        if (term_o)   begin got_term = 1; ended = 1; end_cnt = cnt; end
        if (retire_o) begin got_ret = 1;  ended = 1; end_cnt = cnt; end
    endtask

    task automatic start(int chan, bit ien);
        cnt = 0; wbn = 0; ended = 0; got_term = 0; got_ret = 0; end_cnt = -1;
        @(negedge clk); st_clr_i = 1;
        @(negedge clk); st_clr_i = 0;
        act_i = 1; act_chan_i = CW'(chan); act_irq_en_i = ien;
        @(negedge clk); act_i = 0;
    endtask

    task automatic run_case(int kind, int s, int k, int n, int b, int chan, bit ien);
        bit eret, logged, has_wb;
        int ebeats, widx;
        string t;
        start(chan, ien);
        for (int q = 0; q < n && !ended; q++) begin
            seq_final_i = (q == n - 1);
            @(negedge clk);
            if ((kind == 3 || kind == 4) && q == s) begin
                cx_req_i = (kind == 3); ecx_req_i = (kind == 4);
                @(negedge clk); cx_req_i = 0; ecx_req_i = 0;
                @(negedge clk); @(negedge clk);
            end
            for (int ph = 0; ph < 2 && !ended; ph++)
                for (int j = 0; j < b && !ended; j++)
                    drive_beat(ph[0], j == b - 1,
                               q == s && j == k && ((kind == 1 && ph == 0) || (kind == 2 && ph == 1)));
        end
        seq_final_i = 0;
        @(negedge clk); @(negedge clk);
        t = tag_of(kind, s, k, n, b);
        ebeats = exp_beats(kind, s, k, n, b, eret);
        chk({t, " end beat"}, 64'(end_cnt), 64'(ebeats));
        chk({t, " term"}, 64'(got_term), 64'(!eret));
        chk({t, " retire"}, 64'(got_ret), 64'(eret));
        has_wb = (kind == 1 || kind == 2 || ((kind == 3 || kind == 4) && !eret));
        chk({t, " R3 wb count"}, 64'(wbn), 64'(has_wb));
        if (has_wb) begin
            if (kind == 1)      widx = s * 2 * b + k;
            else if (kind == 2) widx = s * 2 * b + b + k;
            else                widx = ebeats - 1;
            chk({t, " R3 wb src"}, 64'(ws), 64'(src_of(widx)));
            chk({t, " R3 wb dst"}, 64'(wd), 64'(dst_of(widx)));
            chk({t, " R3 wb nbytes"}, 64'(wn), 64'(nb_of(widx)));
        end
        logged = (kind == 1 || kind == 2 || (kind == 4 && !eret));
        chk({t, " status valid"}, 64'(st_valid_o), 64'(logged));
        if (logged) begin
            chk({t, " status chan"}, 64'(st_chan_o), 64'(chan));
            chk({t, " cause bits"}, {61'd0, st_src_err_o, st_dst_err_o, st_ecx_o},
                {61'd0, kind == 1, kind == 2, kind == 4});
        end
        chk({t, " R10 irq"}, 64'(err_irq_o), 64'(logged && ien));
        chk({t, " R11 pend cleared"}, 64'({cx_pend_o, ecx_pend_o}), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {54'd0, term_o, retire_o, wb_valid_o, cx_pend_o, ecx_pend_o,
                           st_valid_o, st_src_err_o, st_dst_err_o, st_ecx_o, err_irq_o}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R11 pending bits set then clear themselves (no channel active)
        cx_req_i = 1; @(negedge clk); cx_req_i = 0;
        chk("R11 cx pend set", 64'(cx_pend_o), 64'd1);
        @(negedge clk);
        chk("R11 cx pend cleared", 64'(cx_pend_o), 64'd0);
        ecx_req_i = 1; @(negedge clk); ecx_req_i = 0;
        chk("R11 ecx pend set", 64'(ecx_pend_o), 64'd1);
        @(negedge clk);
        chk("R11 ecx pend cleared", 64'(ecx_pend_o), 64'd0);
        chk("R11 idle request not logged", 64'(st_valid_o), 64'd0);

        // Directed corners
        run_case(1, 0, 0, 2, 2, 3, 1);   // R2
        run_case(1, 0, 1, 2, 2, 4, 1);   // R4
        run_case(2, 0, 1, 3, 2, 5, 1);   // R5 non-final
        run_case(2, 1, 0, 2, 1, 6, 1);   // R5 final sequence, single-beat phases
        run_case(2, 1, 0, 2, 3, 7, 0);   // R6 and R10 disabled interrupt
        run_case(3, 0, 0, 3, 2, 8, 1);   // R7
        run_case(3, 1, 0, 2, 2, 9, 1);   // R8 plain cancel
        run_case(4, 2, 0, 3, 2, 10, 1);  // R8 error cancel
        run_case(4, 1, 0, 3, 1, 11, 1);  // R9
        run_case(0, 0, 0, 2, 2, 12, 1);  // R13

        // R12: read error on last read, then write error during the deferred writes
        start(21, 1);
        seq_final_i = 0;
        @(negedge clk);
        drive_beat(0, 0, 0);
        drive_beat(0, 1, 1);
        chk("R4 no stop after last-read error", 64'(ended), 64'd0);
        drive_beat(1, 0, 1);
        @(negedge clk);
        chk("R12 term after write error", 64'(got_term), 64'd1);
        chk("R12 end beat", 64'(end_cnt), 64'd3);
        chk("R12 wb count", 64'(wbn), 64'd2);
        chk("R12 newest wb src", 64'(ws), 64'(src_of(2)));
        chk("R12 newest cause", {61'd0, st_src_err_o, st_dst_err_o, st_ecx_o}, 64'b010);
        chk("R12 chan", 64'(st_chan_o), 64'd21);
        chk("R10 irq set", 64'(err_irq_o), 64'd1);
        st_clr_i = 1; @(negedge clk); st_clr_i = 0;
        chk("R12 clear valid", 64'(st_valid_o), 64'd0);
        chk("R10 clear irq", 64'(err_irq_o), 64'd0);

        // Random runs
        for (int r = 0; r < 80; r++) begin
            int n, b, kind, s, k;
            n = 1 + int'($urandom % 4);
            b = 1 + int'($urandom % 3);
            kind = int'($urandom % 5);
            s = int'($urandom % n);
            k = int'($urandom % b);
            run_case(kind, s, k, n, b, int'($urandom % 32), 1'($urandom % 2));
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule